// File: doc/BRIEF.md
# Width-Selectable Up/Down Event Counter with Compare and PWM

This block is a 10-bit counter whose active width can be reduced at run time to 8, 6 or 4 bits. At each count step it moves up or down by one and wraps at the edge of the active width. Software can also load it with a value at any time. A count step comes from one of eight enable sources. Six are single-cycle tick pulses from a prescaler outside the block. The other two are asynchronous event pins, synchronised inside the block, and each rising edge on the selected pin gives one step.

A programmed compare value is checked against the count after each step. The check covers either all ten bits or only the active width. A step that lands on the compare value sets a sticky compare interrupt, and a step that lands on zero sets a sticky zero interrupt. Writing ones to the flag location clears the flags. A PWM output is high while the count lies below the compare value, so a free-running count gives a duty cycle set by the compare value.

Software reaches the block through a plain write strobe with address and data and a combinational read mux. The asynchronous reset is released through a two-stage synchroniser.

Top module: `fwc_counter`

## Requirements
- R1: After reset the count, compare value, control byte and both flags are zero, and `pwm_out` is low.
- R2: Width mode `ctrl[1:0]` picks 10, 8, 6 or 4 active bits (codes 0..3). Bits above the active width always read zero: a mode write masks the count at once. Counting wraps at the active width.
- R3: `ctrl[2]`=0 makes a step add one and `ctrl[2]`=1 makes a step subtract one, both modulo the active width.
- R4: A write to address 1 loads the written data, masked to the active width, into the count in the same cycle. A load never sets a flag.
- R5: `ctrl[5:3]` selects the step source: codes 0..5 are `tick_taps[0..5]`, code 6 is `evt_a` and code 7 is `evt_b`. Steps happen only when run bit `ctrl[7]` is 1. Pulses on unselected sources are ignored.
- R6: The event pins pass through two synchroniser flops. One step is taken per rising edge, on the third rising clock edge after the pin goes high, however long the pin then stays high.
- R7: When `ctrl[6]`=0 the compare checks all 10 bits. When `ctrl[6]`=1 it checks only the active width.
- R8: A step whose new count matches the compare value sets `irq_cmp`, which stays set until it is cleared.
- R9: A step whose new count is zero sets `irq_zero`, which stays set until it is cleared.
- R10: Writing address 3 with bit 0 set clears `irq_cmp`, and with bit 1 set clears `irq_zero`. Zero bits leave their flag unchanged.
- R11: `pwm_out` is high exactly when the current count is below the compare value. The compare value is reduced to the active width when `ctrl[6]`=1.
- R12: Reads return the control byte at address 0, the count at address 1, the compare value at address 2 and `{irq_zero, irq_cmp}` at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_taps | input | 6 | Single-cycle enable pulses from prescaler taps |
| evt_a | input | 1 | Asynchronous event pin A |
| evt_b | input | 1 | Asynchronous event pin B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 ctrl, 1 count load, 2 compare, 3 flag clear) |
| wr_data | input | 10 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 10 | Combinational read data |
| irq_cmp | output | 1 | Sticky compare-match interrupt |
| irq_zero | output | 1 | Sticky zero-reached interrupt |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Register writes, loads, tick steps, flag updates and the PWM level all take effect at the clock edge that samples the strobe or pulse. The bench drives stimulus at the falling edge and checks count, flags and PWM at the next falling edge. An event-pin edge needs three clock edges before the count moves, so event checks wait four full cycles with the pin held high and then re-check after the pin falls. This shows that a single edge gives only one step. Reads are combinational, and each one is sampled a short delay after the read address is set.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_CMP   = 2'd2,
    ADDR_FLAGS = 2'd3
  } fwc_addr_e;

  typedef struct packed {
    logic             run;
    logic             lim_cmp;
    logic [SEL_W-1:0] src;
    logic             down;
    logic [1:0]       wmode;
  } fwc_ctrl_t;
endpackage

// File: rtl/fwc_src_sel.sv
module fwc_src_sel #(
  parameter int N_TAPS = 6,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TAPS-1:0] taps,
  input  logic [1:0]        evt,
  input  logic              run,
  input  logic [SEL_W-1:0]  sel,
  output logic              step
);
  localparam int N_SRC = N_TAPS + 2;

  logic [1:0] evt_rise;

  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [2:0] sh_q, sh_d;
    always_comb sh_d = {sh_q[1:0], evt[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end
    assign evt_rise[g] = sh_q[1] & ~sh_q[2];
  end

  logic [N_SRC-1:0] src_vec;
  logic             pick;

  always_comb begin
    src_vec = {evt_rise, taps};
    pick    = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (int'(sel) == i) pick = src_vec[i];
    end
    step = run & pick;
  end
endmodule

// File: rtl/fwc_count_core.sv
module fwc_count_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             down,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] mask_nx,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] stepped;

  always_comb begin
    stepped = down ? (cnt_q - 1'b1) : (cnt_q + 1'b1);
    if (load)      cnt_d = load_val & mask_nx;
    else if (step) cnt_d = stepped & mask_nx;
    else           cnt_d = cnt_q & mask_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fwc_cmp_irq.sv
module fwc_cmp_irq #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] cmp_d,
  input  logic [CNT_W-1:0] mask_d,
  input  logic             lim_d,
  input  logic             set_en,
  input  logic             clr_cmp,
  input  logic             clr_zero,
  output logic             irq_cmp,
  output logic             irq_zero,
  output logic             pwm_out
);
  logic [CNT_W-1:0] cmp_eff;
  logic             match, below;
  logic             fc_d, fz_d, pwm_d;

  always_comb begin
    cmp_eff = lim_d ? (cmp_d & mask_d) : cmp_d;
    match   = (cnt_d == cmp_eff);
    below   = (cnt_d <  cmp_eff);
    fc_d    = (irq_cmp  & ~clr_cmp)  | (set_en & match);
    fz_d    = (irq_zero & ~clr_zero) | (set_en & (cnt_d == '0));
    pwm_d   = below;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_cmp  <= 1'b0;
      irq_zero <= 1'b0;
      pwm_out  <= 1'b0;
    end else begin
      irq_cmp  <= fc_d;
      irq_zero <= fz_d;
      pwm_out  <= pwm_d;
    end
  end
endmodule

// File: rtl/fwc_counter.sv
module fwc_counter
  import fwc_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int N_TAPS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TAPS-1:0] tick_taps,
  input  logic              evt_a,
  input  logic              evt_b,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [1:0]        rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq_cmp,
  output logic              irq_zero,
  output logic              pwm_out
);
  localparam int CTRL_W = $bits(fwc_ctrl_t);

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  function automatic logic [CNT_W-1:0] mask_of(input logic [1:0] m);
    logic [CNT_W-1:0] ones;
    ones = '1;
    return ones >> (2 * int'(m));
  endfunction

  fwc_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] mask_q, mask_d;
  logic             cfg_wr, ld_stb, cmp_wr, clr_cmp, clr_zero;
  logic             step;
  logic [CNT_W-1:0] cnt_d, cnt_q;

  always_comb begin
    cfg_wr   = wr_en && (wr_addr == ADDR_CTRL);
    ld_stb   = wr_en && (wr_addr == ADDR_COUNT);
    cmp_wr   = wr_en && (wr_addr == ADDR_CMP);
    clr_cmp  = wr_en && (wr_addr == ADDR_FLAGS) && wr_data[0];
    clr_zero = wr_en && (wr_addr == ADDR_FLAGS) && wr_data[1];
    ctrl_d   = cfg_wr ? fwc_ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;
    cmp_d    = cmp_wr ? wr_data : cmp_q;
    mask_q   = mask_of(ctrl_q.wmode);
    mask_d   = mask_of(ctrl_d.wmode);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cmp_q  <= cmp_d;
    end
  end

  fwc_src_sel #(.N_TAPS(N_TAPS), .SEL_W(SEL_W)) u_src (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .taps  (tick_taps),
    .evt   ({evt_b, evt_a}),
    .run   (ctrl_q.run),
    .sel   (ctrl_q.src),
    .step  (step)
  );

  fwc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step     (step),
    .down     (ctrl_q.down),
    .load     (ld_stb),
    .load_val (wr_data),
    .mask_nx  (mask_d),
    .cnt_d    (cnt_d),
    .cnt_q    (cnt_q)
  );

  fwc_cmp_irq #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cnt_d    (cnt_d),
    .cmp_d    (cmp_d),
    .mask_d   (mask_d),
    .lim_d    (ctrl_d.lim_cmp),
    .set_en   (step & ~ld_stb),
    .clr_cmp  (clr_cmp),
    .clr_zero (clr_zero),
    .irq_cmp  (irq_cmp),
    .irq_zero (irq_zero),
    .pwm_out  (pwm_out)
  );

  always_comb begin
    rd_data = '0;
    case (fwc_addr_e'(rd_addr))
      ADDR_CTRL:  rd_data[CTRL_W-1:0] = ctrl_q;
      ADDR_COUNT: rd_data = cnt_q;
      ADDR_CMP:   rd_data = cmp_q;
      default:    rd_data[1:0] = {irq_zero, irq_cmp};
    endcase
  end
endmodule

// File: rtl/fwc_counter_chk.sv
module fwc_counter_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] mask_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic             lim_q,
  input logic             dir_q,
  input logic             step,
  input logic             ld_stb,
  input logic             cfg_wr,
  input logic             clr_cmp,
  input logic             clr_zero,
  input logic             irq_cmp,
  input logic             irq_zero,
  input logic             pwm_out
);
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q & ~mask_q) == '0);

  assert_step_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_stb && !cfg_wr) |=>
      cnt_q == (($past(dir_q) ? ($past(cnt_q) - 1'b1) : ($past(cnt_q) + 1'b1)) & mask_q));

  assert_hold_no_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld_stb && !cfg_wr) |=> $stable(cnt_q));

  assert_cmp_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cmp && !clr_cmp) |=> irq_cmp);

  assert_zero_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_zero && !clr_zero) |=> irq_zero);

  assert_zero_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_zero) |-> (cnt_q == '0));

  assert_pwm_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out == (lim_q ? (cnt_q < (cmp_q & mask_q)) : (cnt_q < cmp_q)));
endmodule

bind fwc_counter fwc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cnt_q    (cnt_q),
  .mask_q   (mask_q),
  .cmp_q    (cmp_q),
  .lim_q    (ctrl_q.lim_cmp),
  .dir_q    (ctrl_q.down),
  .step     (step),
  .ld_stb   (ld_stb),
  .cfg_wr   (cfg_wr),
  .clr_cmp  (clr_cmp),
  .clr_zero (clr_zero),
  .irq_cmp  (irq_cmp),
  .irq_zero (irq_zero),
  .pwm_out  (pwm_out)
);

// File: tb/fwc_counter_bench.sv
`timescale 1ns/1ps
module fwc_counter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] tick_taps = '0;
  logic       evt_a = 1'b0, evt_b = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [9:0] rd_data;
  logic       irq_cmp, irq_zero, pwm_out;

  always #4 clk = ~clk;

  fwc_counter u_fwc_counter (
    .clk(clk), .rst_n(rst_n), .tick_taps(tick_taps), .evt_a(evt_a), .evt_b(evt_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_cmp(irq_cmp), .irq_zero(irq_zero), .pwm_out(pwm_out)
  );

  int checks = 0, failures = 0;
  logic [9:0] m_cnt = '0, m_cmp = '0;
  logic [1:0] m_mode = '0;
  logic [2:0] m_src = '0;
  logic       m_down = 0, m_lim = 0, m_run = 0, m_fc = 0, m_fz = 0;

  function automatic logic [9:0] mask_f(input logic [1:0] m);
    return 10'((1 << (10 - 2 * int'(m))) - 1);
  endfunction

  function automatic logic pwm_f();
    if (m_lim) return m_cnt < (m_cmp & mask_f(m_mode));
    return m_cnt < m_cmp;
  endfunction

  function automatic logic [7:0] ctrl_f();
    return {m_run, m_lim, m_src, m_down, m_mode};
  endfunction

  task automatic chk(input logic [9:0] act, input logic [9:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [9:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(input logic [1:0] mode, input logic down, input logic lim,
                          input logic [2:0] src, input logic run);
    m_mode = mode; m_down = down; m_lim = lim; m_src = src; m_run = run;
    m_cnt  = m_cnt & mask_f(mode);
    wr(2'd0, {2'b00, ctrl_f()});
  endtask

  task automatic do_load(input logic [9:0] v);
    m_cnt = v & mask_f(m_mode);
    wr(2'd1, v);
  endtask

  task automatic do_cmp(input logic [9:0] v);
    m_cmp = v;
    wr(2'd2, v);
  endtask

  task automatic do_clr(input logic [1:0] b);
    if (b[0]) m_fc = 0;
    if (b[1]) m_fz = 0;
    wr(2'd3, {8'd0, b});
  endtask

  task automatic model_step();
    logic [9:0] mk;
    mk = mask_f(m_mode);
    m_cnt = (m_down ? m_cnt - 10'd1 : m_cnt + 10'd1) & mk;
    if (m_lim ? (m_cnt == (m_cmp & mk)) : (m_cnt == m_cmp)) m_fc = 1;
    if (m_cnt == 10'd0) m_fz = 1;
  endtask

  task automatic tick(input int k);
    @(negedge clk);
    tick_taps = 6'(1 << k);
    @(negedge clk);
    tick_taps = '0;
    if (m_run && int'(m_src) == k) model_step();
  endtask

  task automatic evt_pulse(input bit which_b);
    @(negedge clk);
    if (which_b) evt_b = 1'b1; else evt_a = 1'b1;
    repeat (4) @(negedge clk);
    if (which_b) evt_b = 1'b0; else evt_a = 1'b0;
    if (m_run && m_src == (which_b ? 3'd7 : 3'd6)) model_step();
  endtask

  task automatic check_all(input string tag);
    logic [9:0] v;
    rd(2'd1, v); chk(v, m_cnt, {tag, " R2 R3 count"});
    rd(2'd3, v); chk(v, {8'd0, m_fz, m_fc}, {tag, " R8 R9 R12 flags"});
    chk({9'd0, irq_cmp}, {9'd0, m_fc}, {tag, " R8 irq_cmp"});
    chk({9'd0, irq_zero}, {9'd0, m_fz}, {tag, " R9 irq_zero"});
    chk({9'd0, pwm_out}, {9'd0, pwm_f()}, {tag, " R11 pwm"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [9:0] v;
    int unsigned seed;
    seed = $urandom(32'd5521);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk(v, 10'd0, "R1 ctrl");
    rd(2'd2, v); chk(v, 10'd0, "R1 cmp");
    check_all("R1");

    // R2 wrap in 4-bit mode, R9 zero flag
    set_ctrl(2'd3, 0, 0, 3'd0, 1);
    rd(2'd0, v); chk(v, {2'b00, ctrl_f()}, "R12 ctrl readback");
    do_load(10'd14);
    tick(0); check_all("R2 to 15");
    tick(0); check_all("R2 wrap R9");
    chk({9'd0, irq_zero}, 10'd1, "R9 zero flag set on wrap");
    // R3 down across zero
    set_ctrl(2'd3, 1, 0, 3'd0, 1);
    tick(0); check_all("R3 down wrap");
    chk(m_cnt, 10'd15, "R3 model 15");
    // R4 masked load, no flags
    do_clr(2'b11);
    do_load(10'h3FF); check_all("R4 masked load");
    rd(2'd1, v); chk(v, 10'd15, "R4 load value");
    // R7 limited compare
    do_cmp(10'h3F5);
    rd(2'd2, v); chk(v, 10'h3F5, "R12 cmp readback");
    set_ctrl(2'd3, 0, 1, 3'd0, 1);
    do_load(10'd4); tick(0); check_all("R7 limited");
    chk({9'd0, irq_cmp}, 10'd1, "R7 R8 limited match");
    // R10 clear only compare flag
    do_clr(2'b01); check_all("R10 clear");
    // R7 full compare: no match in 4-bit
    set_ctrl(2'd3, 0, 0, 3'd0, 1);
    do_load(10'd4); tick(0); check_all("R7 full");
    chk({9'd0, irq_cmp}, 10'd0, "R7 full no match");
    // R5 run off and wrong tap
    set_ctrl(2'd0, 0, 0, 3'd2, 0);
    tick(2); check_all("R5 run off");
    set_ctrl(2'd0, 0, 0, 3'd2, 1);
    tick(1); check_all("R5 wrong tap");
    tick(2); check_all("R5 right tap");
    // R6 events
    set_ctrl(2'd0, 0, 0, 3'd6, 1);
    do_load(10'd100);
    evt_pulse(0); check_all("R6 evt_a");
    repeat (4) @(negedge clk); check_all("R6 single step");
    evt_pulse(1); check_all("R6 evt_b ignored");
    set_ctrl(2'd0, 1, 0, 3'd7, 1);
    evt_pulse(1); check_all("R6 evt_b down");
    repeat (4) @(negedge clk);

    // constrained random
    for (int it = 0; it < 500; it++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0: set_ctrl(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
                    3'($urandom % 6), ($urandom % 4) != 0);
        1: do_load(10'($urandom));
        2: do_cmp(($urandom % 2) ? 10'($urandom % 16) : 10'($urandom));
        6: do_clr(2'($urandom % 4));
        7: tick(int'(m_src) < 6 ? int'(m_src) : 0);
        default: tick(int'($urandom % 6));
      endcase
      check_all("rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule